// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block holds the four-state coherence status (Modified, Exclusive, Shared, Invalid) of every line for a group of caching agents. All agents share one snooping bus. Each agent takes load and store requests from its core. It finishes a request at once when the local state allows it. Otherwise it asks the bus arbiter for a slot and issues a read, a read-for-ownership or an upgrade. While a peer's transaction is on the bus, every other agent looks up the same line. It reports whether it holds a copy, and whether its copy is the only dirty one that must supply the data. It then adjusts its own state.

A core holds its request until `ready` is high at a clock edge. `rsp_state` gives the state the line has once that edge has passed. At most one bus transaction happens per cycle. A round-robin arbiter picks it. The transaction is visible on the `bus_*` outputs during that cycle.

Top module: `coh_fabric`

## Requirements
- R1: After reset every line of every agent is Invalid (encoding I=0, S=1, E=2, M=3). The first load by any agent therefore needs a bus transaction, and no `ready` or `bus_valid` is high while no request is pending.
- R2: A load to an Invalid line issues a bus read (`bus_cmd`=1). If no peer asserts `bus_shared`, the line ends Exclusive (`rsp_state`=2).
- R3: A load miss while a peer holds a valid copy sees `bus_shared`=1 and ends Shared (`rsp_state`=1). A peer that held Exclusive drops to Shared.
- R4: A load to a Shared, Exclusive or Modified line completes in the cycle it is presented. It makes no bus transaction and leaves the state unchanged.
- R5: A store to an Exclusive line completes in the cycle it is presented. It makes no bus transaction and ends Modified (`rsp_state`=3).
- R6: A store to a Shared line issues an upgrade (`bus_cmd`=3) and ends Modified. Every peer copy becomes Invalid, so a later load by a peer misses.
- R7: A store to an Invalid line issues a read-for-ownership (`bus_cmd`=2) and ends Modified. Every peer copy becomes Invalid.
- R8: When a peer read hits a Modified line, the holder drives `bus_flush`=1 and `bus_owner` carries its index. The holder moves to Shared.
- R9: When a peer read-for-ownership hits a Modified line, the holder supplies the data (`bus_flush`=1, `bus_owner`). The holder moves to Invalid.
- R10: At most one agent is granted per cycle. Grants rotate round-robin, starting after the last agent granted, beginning at agent 0 after reset.
- R11: A transaction on one line leaves the state of every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | NAGENT | Per-agent request present, held until ready |
| req_store | input | NAGENT | Per-agent request is a store (1) or a load (0) |
| req_line | input | NAGENT*LINE_W | Per-agent line index, agent i in bits [i*LINE_W +: LINE_W] |
| ready | output | NAGENT | Request of that agent completes at this clock edge |
| rsp_state | output | 2*NAGENT | State of the requested line after completion, 2 bits per agent |
| bus_valid | output | 1 | A bus transaction occupies this cycle |
| bus_cmd | output | 2 | 1 read, 2 read-for-ownership, 3 upgrade |
| bus_src | output | SRC_W | Index of the requesting agent |
| bus_line | output | LINE_W | Line of the transaction |
| bus_shared | output | 1 | Some peer holds a valid copy of the line |
| bus_flush | output | 1 | A peer holds the line Modified and supplies its data |
| bus_owner | output | SRC_W | Index of the agent supplying data |

## Verification
Assertions check on every cycle that at most one agent is granted and that only a requesting agent is granted. They check that at most one peer claims the dirty copy of the snooped line, that every finished store leaves its line Modified, and that a snooped read or ownership request drives the snooper to Shared/Invalid or Invalid. Sequences that span agents need the bench's directed scenarios. These include Exclusive versus Shared fills, a silent Exclusive-to-Modified store, invalidation that shows up as a later miss, dirty supply on read and on ownership, isolation between lines, and round-robin order against a pending lower index.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RDX  = 2'd2,
    CMD_UPG  = 2'd3
  } bus_cmd_t;
endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb #(
  parameter int NREQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] grant
);
  localparam int PW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [PW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  always_comb begin
    logic found;
    grant  = '0;
    found  = 1'b0;
    ptr_d  = ptr_q;
    for (int off = 0; off < NREQ; off++) begin
      int idx;
      idx = (int'(ptr_q) + off) % NREQ;
      if (!found && req[idx]) begin
        grant[idx] = 1'b1;
        found      = 1'b1;
        ptr_d      = PW'((idx + 1) % NREQ);
      end
    end
    ptr_en = |req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);  // R10
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));  // R10
endmodule

// File: rtl/coh_agent.sv
module coh_agent
  import coh_pkg::*;
#(
  parameter int NAGENT = 4,
  parameter int LINES  = 4,
  parameter int ID     = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_store,
  input  logic [$clog2(LINES)-1:0]     req_line,
  input  logic                         grant,
  input  logic                         bus_valid,
  input  bus_cmd_t                     bus_cmd,
  input  logic [$clog2(NAGENT)-1:0]    bus_src,
  input  logic [$clog2(LINES)-1:0]     bus_line,
  input  logic                         bus_shared,
  output logic                         bus_req,
  output bus_cmd_t                     my_cmd,
  output logic                         ready,
  output line_st_t                     rsp_state,
  output logic                         snoop_hit,
  output logic                         snoop_dirty
);
  localparam int LW = $clog2(LINES);
  localparam int SW = $clog2(NAGENT);
  localparam logic [SW-1:0] MY_ID = SW'(ID);

  line_st_t st_q [LINES];
  line_st_t st_d [LINES];
  line_st_t cur_st;
  line_st_t snp_st;
  logic     hit, clash, local_ok, peer, st_en;

  always_comb begin
    cur_st   = st_q[req_line];
    snp_st   = st_q[bus_line];
    peer     = bus_valid && (bus_src != MY_ID);
    hit      = req_valid && (req_store ? (cur_st == ST_E || cur_st == ST_M)
                                       : (cur_st != ST_I));
    clash    = peer && (bus_line == req_line);
    local_ok = hit && !clash;
    bus_req  = req_valid && !hit;
    if (!req_store)           my_cmd = CMD_RD;
    else if (cur_st == ST_S)  my_cmd = CMD_UPG;
    else                      my_cmd = CMD_RDX;
    ready    = local_ok || grant;
    if (req_store)   rsp_state = ST_M;
    else if (grant)  rsp_state = bus_shared ? ST_S : ST_E;
    else             rsp_state = cur_st;
    snoop_hit   = peer && (snp_st != ST_I);
    snoop_dirty = peer && (snp_st == ST_M);
    st_en       = ready || peer;
  end

  always_comb begin
    for (int l = 0; l < LINES; l++) begin
      st_d[l] = st_q[l];
      if (ready && (req_line == LW'(l))) begin
        st_d[l] = rsp_state;
      end else if (peer && (bus_line == LW'(l))) begin
        if (bus_cmd == CMD_RD) begin
          if (st_q[l] != ST_I) st_d[l] = ST_S;
        end else begin
          st_d[l] = ST_I;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) st_q[l] <= ST_I;
    end else if (st_en) begin
      for (int l = 0; l < LINES; l++) st_q[l] <= st_d[l];
    end
  end

  AST_STORE_ENDS_M: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_store) |=> (st_q[$past(req_line)] == ST_M));  // R6
  AST_PEER_OWN_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_src != MY_ID && bus_cmd != CMD_RD)
      |=> (st_q[$past(bus_line)] == ST_I));  // R7
  AST_PEER_READ_DEMOTES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_src != MY_ID && bus_cmd == CMD_RD)
      |=> (st_q[$past(bus_line)] == ST_S || st_q[$past(bus_line)] == ST_I));  // R8
  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> req_valid);  // R4
endmodule

// File: rtl/coh_fabric.sv
module coh_fabric
  import coh_pkg::*;
#(
  parameter int NAGENT = 4,
  parameter int LINES  = 4,
  localparam int LINE_W = $clog2(LINES),
  localparam int SRC_W  = $clog2(NAGENT)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NAGENT-1:0]          req_valid,
  input  logic [NAGENT-1:0]          req_store,
  input  logic [NAGENT*LINE_W-1:0]   req_line,
  output logic [NAGENT-1:0]          ready,
  output logic [2*NAGENT-1:0]        rsp_state,
  output logic                       bus_valid,
  output logic [1:0]                 bus_cmd,
  output logic [SRC_W-1:0]           bus_src,
  output logic [LINE_W-1:0]          bus_line,
  output logic                       bus_shared,
  output logic                       bus_flush,
  output logic [SRC_W-1:0]           bus_owner
);
  logic [1:0]        rst_sync;
  logic              rst_ok_n;
  logic [NAGENT-1:0] breq, grant, s_hit, s_dirty;
  bus_cmd_t          a_cmd [NAGENT];
  line_st_t          a_rsp [NAGENT];
  bus_cmd_t          cmd_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok_n = rst_sync[1];

  coh_rr_arb #(.NREQ(NAGENT)) u_arb (
    .clk(clk), .rst_n(rst_ok_n), .req(breq), .grant(grant)
  );

  always_comb begin
    cmd_w     = CMD_NONE;
    bus_src   = '0;
    bus_line  = '0;
    bus_owner = '0;
    for (int i = 0; i < NAGENT; i++) begin
      if (grant[i]) begin
        cmd_w    = a_cmd[i];
        bus_src  = SRC_W'(i);
        bus_line = req_line[i*LINE_W +: LINE_W];
      end
      if (s_dirty[i]) bus_owner = SRC_W'(i);
    end
    bus_valid  = |grant;
    bus_cmd    = cmd_w;
    bus_shared = |s_hit;
    bus_flush  = |s_dirty;
  end

  for (genvar g = 0; g < NAGENT; g++) begin : g_agent
    coh_agent #(.NAGENT(NAGENT), .LINES(LINES), .ID(g)) u_agent (
      .clk        (clk),
      .rst_n      (rst_ok_n),
      .req_valid  (req_valid[g]),
      .req_store  (req_store[g]),
      .req_line   (req_line[g*LINE_W +: LINE_W]),
      .grant      (grant[g]),
      .bus_valid  (bus_valid),
      .bus_cmd    (cmd_w),
      .bus_src    (bus_src),
      .bus_line   (bus_line),
      .bus_shared (bus_shared),
      .bus_req    (breq[g]),
      .my_cmd     (a_cmd[g]),
      .ready      (ready[g]),
      .rsp_state  (a_rsp[g]),
      .snoop_hit  (s_hit[g]),
      .snoop_dirty(s_dirty[g])
    );
    assign rsp_state[2*g +: 2] = a_rsp[g];
  end

  AST_ONE_DIRTY_OWNER: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $onehot0(s_dirty));  // R8
  AST_FLUSH_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_ok_n)
    bus_flush |-> (bus_valid && bus_shared));  // R9
endmodule

// File: tb/tb_coh_fabric.sv
module tb_coh_fabric;
  localparam int N  = 4;
  localparam int L  = 4;
  localparam int LW = 2;
  localparam int SW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N-1:0]    req_store = '0;
  logic [N*LW-1:0] req_line = '0;
  logic [N-1:0]    ready;
  logic [2*N-1:0]  rsp_state;
  logic            bus_valid, bus_shared, bus_flush;
  logic [1:0]      bus_cmd;
  logic [SW-1:0]   bus_src, bus_owner;
  logic [LW-1:0]   bus_line;

  int n_chk = 0;
  int n_bad = 0;

  int c_rsp, c_bv, c_cmd, c_sh, c_fl, c_own;

  coh_fabric #(.NAGENT(N), .LINES(L)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_line(req_line), .ready(ready), .rsp_state(rsp_state),
    .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_src(bus_src),
    .bus_line(bus_line), .bus_shared(bus_shared), .bus_flush(bus_flush),
    .bus_owner(bus_owner)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    req_valid = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Present one request, wait for ready, capture the bus view of that cycle.
  task automatic access(input int a, input bit st, input int ln);
    int waited;
    @(negedge clk);
    req_store[a] = st;
    req_line[a*LW +: LW] = LW'(ln);
    req_valid[a] = 1'b1;
    #1;
    waited = 0;
    while (!ready[a] && waited < 20) begin
      @(negedge clk); #1;
      waited++;
    end
    c_rsp = int'(rsp_state[2*a +: 2]);
    c_bv  = int'(bus_valid);
    c_cmd = int'(bus_cmd);
    c_sh  = int'(bus_shared);
    c_fl  = int'(bus_flush);
    c_own = int'(bus_owner);
    if (!ready[a]) chk("access ready", 0, 1);
    @(posedge clk); #1;
    req_valid[a] = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    chk("R1 ready idle", int'(ready), 0);
    chk("R1 bus idle", int'(bus_valid), 0);
    access(2, 1'b0, 0);
    chk("R1 first load on bus", c_bv, 1);
  endtask

  task automatic t_fill_and_dirty();
    do_reset();
    access(0, 1'b0, 1);
    chk("R2 read cmd", c_cmd, 1);
    chk("R2 not shared", c_sh, 0);
    chk("R2 exclusive", c_rsp, 2);
    access(0, 1'b0, 1);
    chk("R4 load hit no bus", c_bv, 0);
    chk("R4 state kept", c_rsp, 2);
    access(0, 1'b1, 1);
    chk("R5 silent store no bus", c_bv, 0);
    chk("R5 modified", c_rsp, 3);
    access(1, 1'b0, 1);
    chk("R3 read cmd", c_cmd, 1);
    chk("R3 shared seen", c_sh, 1);
    chk("R3 shared fill", c_rsp, 1);
    chk("R8 flush on read", c_fl, 1);
    chk("R8 owner", c_own, 0);
    access(0, 1'b0, 1);
    chk("R8 holder now shared", c_rsp, 1);
    chk("R8 holder hit no bus", c_bv, 0);
  endtask

  task automatic t_upgrade_and_rfo();
    do_reset();
    access(0, 1'b0, 1);
    access(1, 1'b0, 1);
    chk("R3 exclusive peer demoted", c_rsp, 1);
    access(0, 1'b0, 1);
    chk("R3 peer hit stays shared", c_rsp, 1);
    access(0, 1'b1, 1);
    chk("R6 upgrade cmd", c_cmd, 3);
    chk("R6 modified", c_rsp, 3);
    access(1, 1'b0, 1);
    chk("R6 peer invalidated misses", c_bv, 1);
    chk("R8 flush from upgrader", c_fl, 1);
    chk("R8 owner after upgrade", c_own, 0);
    access(2, 1'b1, 1);
    chk("R7 rfo cmd", c_cmd, 2);
    chk("R7 modified", c_rsp, 3);
    chk("R7 no dirty peer", c_fl, 0);
    access(0, 1'b0, 1);
    chk("R7 peer invalidated misses", c_bv, 1);
    chk("R8 owner 2", c_own, 2);
    access(3, 1'b1, 1);
    chk("R7 rfo over shared", c_cmd, 2);
    access(1, 1'b1, 1);
    chk("R9 rfo cmd", c_cmd, 2);
    chk("R9 flush on rfo", c_fl, 1);
    chk("R9 owner", c_own, 3);
    access(3, 1'b0, 1);
    chk("R9 old holder misses", c_bv, 1);
    chk("R9 new holder supplies", c_own, 1);
  endtask

  task automatic t_line_isolation();
    do_reset();
    access(1, 1'b1, 1);
    access(2, 1'b1, 2);
    chk("R11 other line rfo", c_cmd, 2);
    chk("R11 no sharer of line2", c_sh, 0);
    access(1, 1'b0, 1);
    chk("R11 line1 still hit", c_bv, 0);
    chk("R11 line1 still modified", c_rsp, 3);
  endtask

  task automatic t_round_robin();
    int order [4];
    do_reset();
    @(negedge clk);
    for (int a = 0; a < N; a++) begin
      req_store[a] = 1'b0;
      req_line[a*LW +: LW] = LW'(a);
    end
    req_valid = '1;
    for (int k = 0; k < N; k++) begin
      #1;
      order[k] = int'(bus_src);
      chk("R10 one grant valid", int'(bus_valid), 1);
      @(posedge clk); #1;
      req_valid[order[k]] = 1'b0;
      @(negedge clk);
    end
    for (int k = 0; k < N; k++) chk("R10 reset order", order[k], k);
    access(1, 1'b0, 3);
    @(negedge clk);
    req_line[0 +: LW] = 2'd2;  req_line[3*LW +: LW] = 2'd2;
    req_store[0] = 1'b1;        req_store[3] = 1'b1;
    req_valid[0] = 1'b1;        req_valid[3] = 1'b1;
    #1;
    chk("R10 rotation picks 3", int'(bus_src), 3);
    chk("R10 only 3 ready", int'(ready), 4'b1000);
    @(posedge clk); #1;
    req_valid[3] = 1'b0;
    @(negedge clk); #1;
    chk("R10 then 0", int'(bus_src), 0);
    chk("R9 0 takes line from 3", int'(bus_owner), 3);
    @(posedge clk); #1;
    req_valid[0] = 1'b0;
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_fill_and_dirty();
        t_upgrade_and_rfo();
        t_line_isolation();
        t_round_robin();
      end
      begin
        repeat (20000) @(posedge clk);
        chk("watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule